// File: doc/BRIEF.md
# Output Port with Atomic Set/Clear

This block is a memory-mapped output port for sixteen general-purpose pins. Software reaches it over a plain 32-bit register bus with a byte address, write data, a write strobe, a read strobe and combinational read data. A 16-bit output latch drives the pins directly. Two registers are mapped in the port's register window: an ordinary read/write output data register, and a write-only set/clear register.

The set/clear register lets software raise some pins and lower others in one bus write. It needs no read-modify-write sequence, so a pin update cannot race with another agent's update to different pins. Its low half names pins to drive high and its high half names pins to drive low. Every write acts on its own, so back-to-back writes produce one pin change per write, in order. Reading the set/clear register always returns zero. Reading the output data register shows the latch as it stands, including changes made through set/clear.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every pin is low, and reads of the output data register (byte offset 0x14) and of the set/clear register (offset 0x18) return 0x00000000.
- R2: A write to offset 0x14 loads write-data bits 15:0 into the latch on the edge where the write strobe is sampled, and the pins show that value from then on. Write-data bits 31:16 are ignored.
- R3: A read of offset 0x14 returns the latch in bits 15:0 and zero in bits 31:16.
- R4: Writing 1 to bit n (n = 0..15) of the set/clear register at offset 0x18 drives pin n high.
- R5: Writing 1 to bit 16+n of the set/clear register drives pin n low.
- R6: Pins whose set bit and clear bit are both written as 0 keep their value across a set/clear write.
- R7: When one set/clear write has both bit n and bit 16+n at 1, pin n goes high.
- R8: A read of offset 0x18 returns 0x00000000 whatever the pin state.
- R9: Set/clear writes on consecutive clock cycles each take effect in turn. Setting pin 9, then pin 11, then clearing pin 9, then pin 11 shows four distinct pin states, one per cycle.
- R10: Reads of any offset other than 0x14 and 0x18 return zero, and writes there leave the pins unchanged. With no write strobe the pins hold.
- R11: After a set/clear write, a read of offset 0x14 shows the updated latch.
- R12: While the read strobe is low, read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the port's register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per sampled cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| pins | output | 16 | Output pin levels |

## Verification
On every clocked cycle the assertions check the per-write latch effects. Set bits must land high, clear-only bits must land low, and untouched bits must hold. An output-data write must load the latch exactly, and a cycle with no write, or with a write to an unmapped offset, must leave the pins steady. The assertions also require the set/clear register and the upper half of the data register to read as zero. Only the bench scenarios can show that a long mix of the two write styles, with conflicting bits and random unmapped traffic, keeps the pins and the read-back consistent with an independent model. The same holds for the ordered one-change-per-cycle effect of back-to-back set/clear writes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_CNT = 16;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam logic [ADDR_W-1:0] OFS_OUTDATA = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SETCLR  = 8'h18;

  // Next latch value for one set/clear word: set beats clear, zeros hold.
  function automatic logic [PIN_CNT-1:0] setclr_next(
    input logic [PIN_CNT-1:0] cur,
    input logic [PIN_CNT-1:0] set_m,
    input logic [PIN_CNT-1:0] clr_m
  );
    return set_m | (cur & ~clr_m);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] OUT_OFS = OFS_OUTDATA,
  parameter logic [AW-1:0] SC_OFS  = OFS_SETCLR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          out_wr,
  output logic          sc_wr,
  output logic          out_rd,
  output logic          sc_rd,
  output logic          miss_wr
);
  logic hit_out, hit_sc;

  always_comb begin
    hit_out = (addr == OUT_OFS);
    hit_sc  = (addr == SC_OFS);
    out_wr  = wr & hit_out;
    sc_wr   = wr & hit_sc;
    out_rd  = rd & hit_out;
    sc_rd   = rd & hit_sc;
    miss_wr = wr & ~hit_out & ~hit_sc;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_wr, sc_wr, miss_wr})); // R10
  AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_rd, sc_rd})); // R10
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int NP = PIN_CNT,
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_wr,
  input  logic          sc_wr,
  input  logic [DW-1:0] wdata,
  output logic [NP-1:0] q
);
  localparam int CLR_LSB = NP;

  logic [NP-1:0] set_vec, clr_vec, sc_next, touched;
  logic          any_wr;

  always_comb begin
    set_vec = wdata[NP-1:0];
    clr_vec = wdata[CLR_LSB +: NP];
    sc_next = setclr_next(q, set_vec, clr_vec);
    touched = set_vec | clr_vec;
    any_wr  = out_wr | sc_wr;
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (out_wr) q[i] <= wdata[i];
      else if (sc_wr)  q[i] <= sc_next[i];
    end
  end

  AST_SET_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((q & $past(set_vec)) == $past(set_vec))); // R7
  AST_CLR_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((q & $past(clr_vec & ~set_vec)) == '0)); // R5
  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((q & ~$past(touched)) == ($past(q) & ~$past(touched)))); // R6
  AST_OUTDATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |=> (q == $past(wdata[NP-1:0]))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(q)); // R10
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_port_pkg::*;
#(
  parameter int NP = PIN_CNT,
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          out_rd,
  input  logic          sc_rd,
  input  logic [NP-1:0] latch,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (out_rd) rdata = DW'(latch);
  end

  AST_SETCLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rd |-> (rdata == '0)); // R8
  AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[DW-1:NP] == '0)); // R3
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R12
  AST_OUTDATA_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd |-> (rdata[NP-1:0] == latch)); // R11
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_port_pkg::*;
#(
  parameter int NP = PIN_CNT,
  parameter int DW = BUS_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [NP-1:0] pins
);
  logic out_wr, sc_wr, out_rd, sc_rd, miss_wr;
  logic [NP-1:0] latch_q;

  gpio_addr_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .out_wr(out_wr), .sc_wr(sc_wr), .out_rd(out_rd), .sc_rd(sc_rd),
    .miss_wr(miss_wr)
  );

  gpio_out_latch #(.NP(NP), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .out_wr(out_wr), .sc_wr(sc_wr),
    .wdata(bus_wdata), .q(latch_q)
  );

  gpio_readback #(.NP(NP), .DW(DW)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .out_rd(out_rd), .sc_rd(sc_rd),
    .latch(latch_q), .rdata(bus_rdata)
  );

  assign pins = latch_q;

  AST_MISS_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_wr |=> $stable(pins)); // R10
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (pins == '0)); // R1
endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] pins;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  logic [15:0] model = '0;

  localparam logic [7:0] A_OUT = 8'h14;
  localparam logic [7:0] A_SC  = 8'h18;

  gpio_setclr_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pins(pins)
  );

  always #4 clk = ~clk;

  // Bench's own statement of the set/clear rule, bit by bit.
  function automatic logic [15:0] tb_setclr(input logic [15:0] cur, input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      if (w[i])         r[i] = 1'b1;
      else if (w[16+i]) r[i] = 1'b0;
      else              r[i] = cur[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] tb_read(input logic [7:0] a, input logic [15:0] m);
    if (a == A_OUT) return {16'h0, m};
    return 32'h0;
  endfunction

  function automatic logic [15:0] tb_write(input logic [7:0] a, input logic [31:0] w,
                                           input logic [15:0] m);
    if (a == A_OUT) return w[15:0];
    if (a == A_SC)  return tb_setclr(m, w);
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] w, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model = tb_write(a, w, model);
    check(pins == model, req, {16'h0, pins}, {16'h0, model});
  endtask

  task automatic bus_read(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(bus_rdata == tb_read(a, model), req, bus_rdata, tb_read(a, model));
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pins == 16'h0, "R1", {16'h0, pins}, 32'h0);
    bus_read(A_OUT, "R1");
    bus_read(A_SC, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: upper bits of the data word ignored
    bus_write(A_OUT, 32'hFFFF_A5C3, "R2");
    bus_read(A_OUT, "R3");
    // R12: no read strobe gives zero
    @(negedge clk); bus_addr = A_OUT; #1;
    check(bus_rdata == 32'h0, "R12", bus_rdata, 32'h0);
    // R8: set/clear reads zero with pins non-zero
    bus_read(A_SC, "R8");
    // R4 / R5 / R6
    bus_write(A_OUT, 32'h0000_0000, "R2");
    bus_write(A_SC, 32'h0000_0201, "R4");
    bus_write(A_SC, 32'h0001_0000, "R5");
    bus_write(A_SC, 32'h0000_0000, "R6");
    // R7: conflict, set wins
    bus_write(A_SC, 32'h0020_0020, "R7");
    bus_write(A_SC, 32'h8000_8000, "R7");
    bus_read(A_OUT, "R11");

    // R9: back-to-back writes, one pin change per cycle
    bus_write(A_OUT, 32'h0, "R9");
    @(negedge clk);
    bus_addr = A_SC; bus_wr = 1'b1;
    begin
      logic [31:0] seq [4];
      seq[0] = 32'h0000_0200; seq[1] = 32'h0000_0800;
      seq[2] = 32'h0200_0000; seq[3] = 32'h0800_0000;
      for (int k = 0; k < 4; k++) begin
        bus_wdata = seq[k];
        @(negedge clk);
        model = tb_setclr(model, seq[k]);
        check(pins == model, "R9", {16'h0, pins}, {16'h0, model});
      end
    end
    bus_wr = 1'b0;

    // R10: unmapped offsets
    bus_write(A_OUT, 32'h0000_3C3C, "R2");
    bus_write(8'h1C, 32'hFFFF_FFFF, "R10");
    bus_write(8'h15, 32'h0000_0000, "R10");
    bus_read(8'h00, "R10");
    bus_read(8'h19, "R10");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  a;
      logic [31:0] w;
      int sel;
      sel = $urandom_range(0, 9);
      w = $urandom();
      if (sel < 5)      a = A_SC;
      else if (sel < 7) a = A_OUT;
      else              a = 8'($urandom());
      if ($urandom_range(0, 2) == 0) begin
        bus_read(a, (a == A_OUT) ? "R11" : ((a == A_SC) ? "R8" : "R10"));
      end else begin
        bus_write(a, w, (a == A_SC) ? "R6" : ((a == A_OUT) ? "R2" : "R10"));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule